// File: doc/BRIEF.md
# Two-Port Storage Command Request Controller

This block is the request front end for two user ports that share one storage drive. The main port can issue six command kinds: identify, shutdown, write, read, health-log query and cache flush. The secondary port can issue only write and read. Each port uses a request/busy handshake that carries a 3-bit code, a 48-bit start sector and a 48-bit sector count. Sectors are 512 bytes. The block decides whether each request is legal and whether it may run alongside whatever the other port is doing. Accepted commands go to a back end through a one-cycle start strobe, and the back end ends each command with a done strobe.

After reset, both ports stay busy until the link-up input is seen and a fixed initialization period has elapsed. Read and write requests are checked against the drive capacity and the sector mode. Both values are latched when an identify command completes: the back end presents them on `id_capacity` and `id_sector_4k` in the same cycle as `m_be_done`.

Shutdown takes the whole drive. It is refused while the secondary port is busy. While it runs, the secondary port's requests are refused. Once it completes, both ports go inactive until reset.

Each port runs its own state machine with these states:
- PS_INIT: waiting for initialization.
- PS_IDLE: ready for a request.
- PS_BUSY: a command is running.
- PS_HOLD: a request was refused, and the port waits for the requester to drop it.
- PS_OFF: inactive after shutdown.

The transitions are:
- INIT→IDLE when initialization completes.
- IDLE→BUSY on an accepted request.
- IDLE→HOLD on a refused request.
- HOLD→IDLE when the request falls.
- BUSY→IDLE on done.
- BUSY→OFF on done of a shutdown.
- IDLE/HOLD→OFF when the shutdown on the main port completes.

The initialization sequencer has three states:
- IS_WAIT: waiting for link-up.
- IS_RUN: counting `INIT_CYCLES`.
- IS_DONE: initialization complete.

Top module: `dualport_cmd_ctrl`

## Requirements
- R1: The main port accepts codes 000 identify, 001 shutdown, 010 write, 011 read, 100 health-log query and 110 cache flush. It refuses the reserved codes 101 and 111.
- R2: The secondary port accepts only 010 write and 011 read. Every other code is refused.
- R3: A request that an idle port samples at a clock edge produces, after that edge, `busy` high together with a one-cycle `be_start` that carries the code, sector and count. A request raised while the port is busy has no effect. `busy` falls at the edge that samples `be_done`.
- R4: Both ports may run commands at the same time, except in the shutdown cases of R12.
- R5: From reset, both `busy` outputs stay high and no request is accepted until `link_up` has been seen and `INIT_CYCLES` further cycles have passed.
- R6: `capacity` and `sector_4k` reset to 0. They load `id_capacity` and `id_sector_4k` at the edge that sees `m_be_done` while an identify is running.
- R7: A write or read is refused when sector plus count exceeds `capacity`. A sum equal to `capacity` is accepted.
- R8: When `sector_4k` is 1, a write or read is refused unless bits [2:0] of both the sector and the count are zero.
- R9: A write or read with a count of zero is refused.
- R10: A refused request produces exactly one one-cycle `reject` pulse. `busy` stays low and there is no `be_start`. The port accepts again once the request has been low for one edge.
- R11: When both ports raise requests in the same cycle, the main port is decided first. The secondary port is decided one cycle later against the state the main port has just entered.
- R12: A shutdown is refused while the secondary port is busy. A secondary request is refused while a shutdown runs on the main port.
- R13: After a shutdown completes, both ports are inactive until reset. `locked` and both `busy` outputs are high, and requests give neither `be_start` nor `reject`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_up | input | 1 | Drive link is ready; starts initialization |
| m_req | input | 1 | Main port request |
| m_cmd | input | 3 | Main port command code |
| m_addr | input | 48 | Main port start sector |
| m_len | input | 48 | Main port sector count |
| m_busy | output | 1 | Main port not idle |
| m_reject | output | 1 | One-cycle pulse: main request refused |
| s_req | input | 1 | Secondary port request |
| s_cmd | input | 3 | Secondary port command code |
| s_addr | input | 48 | Secondary port start sector |
| s_len | input | 48 | Secondary port sector count |
| s_busy | output | 1 | Secondary port not idle |
| s_reject | output | 1 | One-cycle pulse: secondary request refused |
| m_be_start | output | 1 | Start strobe to the main back end |
| m_be_cmd | output | 3 | Accepted main command code |
| m_be_addr | output | 48 | Accepted main start sector |
| m_be_len | output | 48 | Accepted main sector count |
| m_be_done | input | 1 | Main back end finished |
| s_be_start | output | 1 | Start strobe to the secondary back end |
| s_be_cmd | output | 3 | Accepted secondary command code |
| s_be_addr | output | 48 | Accepted secondary start sector |
| s_be_len | output | 48 | Accepted secondary sector count |
| s_be_done | input | 1 | Secondary back end finished |
| id_capacity | input | 48 | Capacity reported by identify, in sectors |
| id_sector_4k | input | 1 | Sector mode reported by identify |
| capacity | output | 48 | Latched capacity in 512-byte sectors |
| sector_4k | output | 1 | Latched sector mode: 0 = 512 B, 1 = 4 KB |
| locked | output | 1 | Both ports inactive after shutdown |

## Verification
The hardest situation to reach is two requests landing in the same clock cycle, where one of them is a shutdown. The main port must win. The secondary request is then judged a cycle later and must be refused because a shutdown is now running.

The bench reaches this by raising both requests on the same falling edge. It then compares the order of the start and refuse events against a scoreboard queue. A same-cycle write/read pair exercises the ordinary case, in which both requests are accepted one cycle apart.

Alignment and range limits are reached by issuing a second identify that reports 4 KB mode, then probing the sectors on either side of the limits.

// File: rtl/cmdc_pkg.sv
package cmdc_pkg;
    localparam int CMD_W = 3;

    localparam logic [CMD_W-1:0] OP_IDENT  = 3'b000;
    localparam logic [CMD_W-1:0] OP_SHUT   = 3'b001;
    localparam logic [CMD_W-1:0] OP_WRITE  = 3'b010;
    localparam logic [CMD_W-1:0] OP_READ   = 3'b011;
    localparam logic [CMD_W-1:0] OP_HEALTH = 3'b100;
    localparam logic [CMD_W-1:0] OP_FLUSH  = 3'b110;

    typedef enum logic [2:0] {
        PS_INIT,
        PS_IDLE,
        PS_BUSY,
        PS_HOLD,
        PS_OFF
    } port_state_e;

    typedef enum logic [1:0] {
        IS_WAIT,
        IS_RUN,
        IS_DONE
    } init_state_e;
endpackage

// File: rtl/cmdc_init_seq.sv
module cmdc_init_seq #(
    parameter int INIT_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link_up,
    output logic init_done
);
    import cmdc_pkg::*;

    localparam int CNT_W = (INIT_CYCLES > 1) ? $clog2(INIT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(INIT_CYCLES - 1);

    init_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IS_WAIT: if (link_up) state_d = IS_RUN;
            IS_RUN:  if (cnt_q == CNT_LAST) state_d = IS_DONE;
            IS_DONE: state_d = IS_DONE;
            default: state_d = IS_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IS_WAIT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            init_done <= 1'b0;
        end else begin
            if (state_q == IS_RUN) cnt_q <= cnt_q + 1'b1;
            else                   cnt_q <= '0;
            init_done <= (state_d == IS_DONE);
        end
    end
endmodule

// File: rtl/cmdc_param_check.sv
module cmdc_param_check #(
    parameter bit IS_MAIN = 1'b1,
    parameter int AW      = 48,
    parameter int LW      = 48
) (
    input  logic [2:0]    cmd,
    input  logic [AW-1:0] addr,
    input  logic [LW-1:0] len,
    input  logic [AW-1:0] capacity,
    input  logic          sector_4k,
    output logic          ok
);
    import cmdc_pkg::*;

    localparam int SW = ((AW > LW) ? AW : LW) + 1;

    logic          code_ok;
    logic          is_xfer;
    logic [SW-1:0] end_sum;
    logic          range_ok;
    logic          len_ok;
    logic          align_ok;

    generate
        if (IS_MAIN) begin : g_main_codes
            always_comb begin
                unique case (cmd)
                    OP_IDENT, OP_SHUT, OP_WRITE, OP_READ, OP_HEALTH, OP_FLUSH: code_ok = 1'b1;
                    default: code_ok = 1'b0;
                endcase
            end
        end else begin : g_sec_codes
            always_comb begin
                unique case (cmd)
                    OP_WRITE, OP_READ: code_ok = 1'b1;
                    default: code_ok = 1'b0;
                endcase
            end
        end
    endgenerate

    always_comb begin
        is_xfer  = (cmd == OP_WRITE) || (cmd == OP_READ);
        end_sum  = SW'(addr) + SW'(len);
        range_ok = (end_sum <= SW'(capacity));
        len_ok   = (len != '0);
        align_ok = !sector_4k || ((addr[2:0] == 3'b000) && (len[2:0] == 3'b000));
        ok       = code_ok && (!is_xfer || (range_ok && len_ok && align_ok));
    end
endmodule

// File: rtl/cmdc_port_fsm.sv
module cmdc_port_fsm #(
    parameter bit IS_MAIN = 1'b1,
    parameter int AW      = 48,
    parameter int LW      = 48
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  init_done,
    input  logic                  req,
    input  logic [2:0]            cmd,
    input  logic [AW-1:0]         addr,
    input  logic [LW-1:0]         len,
    input  logic                  params_ok,
    input  logic                  permit,
    input  logic                  defer,
    input  logic                  be_done,
    input  logic                  lock_all,
    output logic                  busy,
    output logic                  reject,
    output logic                  be_start,
    output logic [2:0]            be_cmd,
    output logic [AW-1:0]         be_addr,
    output logic [LW-1:0]         be_len,
    output cmdc_pkg::port_state_e state_o
);
    import cmdc_pkg::*;

    port_state_e state_q, state_d;
    logic        decide;
    logic        accept;
    logic        refuse;

    always_comb begin
        decide = (state_q == PS_IDLE) && req && !defer && !lock_all;
        accept = decide && params_ok && permit;
        refuse = decide && !(params_ok && permit);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_INIT: if (init_done) state_d = PS_IDLE;
            PS_IDLE: begin
                if (lock_all)    state_d = PS_OFF;
                else if (accept) state_d = PS_BUSY;
                else if (refuse) state_d = PS_HOLD;
            end
            PS_BUSY: begin
                if (lock_all) state_d = PS_OFF;
                else if (be_done) begin
                    if (IS_MAIN && (be_cmd == OP_SHUT)) state_d = PS_OFF;
                    else                                state_d = PS_IDLE;
                end
            end
            PS_HOLD: begin
                if (lock_all) state_d = PS_OFF;
                else if (!req) state_d = PS_IDLE;
            end
            PS_OFF:  state_d = PS_OFF;
            default: state_d = PS_INIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_INIT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reject   <= 1'b0;
            be_start <= 1'b0;
            be_cmd   <= '0;
            be_addr  <= '0;
            be_len   <= '0;
        end else begin
            reject   <= refuse;
            be_start <= accept;
            if (accept) begin
                be_cmd  <= cmd;
                be_addr <= addr;
                be_len  <= len;
            end
        end
    end

    assign busy    = (state_q == PS_INIT) || (state_q == PS_BUSY) || (state_q == PS_OFF);
    assign state_o = state_q;
endmodule

// File: rtl/dualport_cmd_ctrl.sv
module dualport_cmd_ctrl #(
    parameter int AW          = 48,
    parameter int LW          = 48,
    parameter int INIT_CYCLES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          link_up,
    input  logic          m_req,
    input  logic [2:0]    m_cmd,
    input  logic [AW-1:0] m_addr,
    input  logic [LW-1:0] m_len,
    output logic          m_busy,
    output logic          m_reject,
    input  logic          s_req,
    input  logic [2:0]    s_cmd,
    input  logic [AW-1:0] s_addr,
    input  logic [LW-1:0] s_len,
    output logic          s_busy,
    output logic          s_reject,
    output logic          m_be_start,
    output logic [2:0]    m_be_cmd,
    output logic [AW-1:0] m_be_addr,
    output logic [LW-1:0] m_be_len,
    input  logic          m_be_done,
    output logic          s_be_start,
    output logic [2:0]    s_be_cmd,
    output logic [AW-1:0] s_be_addr,
    output logic [LW-1:0] s_be_len,
    input  logic          s_be_done,
    input  logic [AW-1:0] id_capacity,
    input  logic          id_sector_4k,
    output logic [AW-1:0] capacity,
    output logic          sector_4k,
    output logic          locked
);
    import cmdc_pkg::*;

    localparam int NP = 2;

    logic          init_done;
    logic          req_a    [NP];
    logic [2:0]    cmd_a    [NP];
    logic [AW-1:0] addr_a   [NP];
    logic [LW-1:0] len_a    [NP];
    logic          done_a   [NP];
    logic          ok_a     [NP];
    logic          permit_a [NP];
    logic          defer_a  [NP];
    logic          busy_a   [NP];
    logic          rej_a    [NP];
    logic          start_a  [NP];
    logic [2:0]    bcmd_a   [NP];
    logic [AW-1:0] baddr_a  [NP];
    logic [LW-1:0] blen_a   [NP];
    port_state_e   st_a     [NP];
    logic          lock_all;
    logic          ident_done;

    assign req_a[0]  = m_req;
    assign cmd_a[0]  = m_cmd;
    assign addr_a[0] = m_addr;
    assign len_a[0]  = m_len;
    assign done_a[0] = m_be_done;
    assign req_a[1]  = s_req;
    assign cmd_a[1]  = s_cmd;
    assign addr_a[1] = s_addr;
    assign len_a[1]  = s_len;
    assign done_a[1] = s_be_done;

    cmdc_init_seq #(.INIT_CYCLES(INIT_CYCLES)) u_init (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_up   (link_up),
        .init_done (init_done)
    );

    // Cross-port rules: shutdown exclusivity and main-first ordering
    always_comb begin
        permit_a[0] = !((cmd_a[0] == OP_SHUT) && (st_a[1] == PS_BUSY));
        permit_a[1] = !((st_a[0] == PS_BUSY) && (bcmd_a[0] == OP_SHUT));
        defer_a[0]  = 1'b0;
        defer_a[1]  = (st_a[0] == PS_IDLE) && req_a[0];
        lock_all    = (st_a[0] == PS_BUSY) && (bcmd_a[0] == OP_SHUT) && done_a[0];
        ident_done  = (st_a[0] == PS_BUSY) && (bcmd_a[0] == OP_IDENT) && done_a[0];
    end

    generate
        for (genvar p = 0; p < NP; p++) begin : g_port
            cmdc_param_check #(.IS_MAIN(p == 0), .AW(AW), .LW(LW)) u_chk (
                .cmd       (cmd_a[p]),
                .addr      (addr_a[p]),
                .len       (len_a[p]),
                .capacity  (capacity),
                .sector_4k (sector_4k),
                .ok        (ok_a[p])
            );

            cmdc_port_fsm #(.IS_MAIN(p == 0), .AW(AW), .LW(LW)) u_fsm (
                .clk       (clk),
                .rst_n     (rst_n),
                .init_done (init_done),
                .req       (req_a[p]),
                .cmd       (cmd_a[p]),
                .addr      (addr_a[p]),
                .len       (len_a[p]),
                .params_ok (ok_a[p]),
                .permit    (permit_a[p]),
                .defer     (defer_a[p]),
                .be_done   (done_a[p]),
                .lock_all  (lock_all),
                .busy      (busy_a[p]),
                .reject    (rej_a[p]),
                .be_start  (start_a[p]),
                .be_cmd    (bcmd_a[p]),
                .be_addr   (baddr_a[p]),
                .be_len    (blen_a[p]),
                .state_o   (st_a[p])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            capacity  <= '0;
            sector_4k <= 1'b0;
        end else if (ident_done) begin
            capacity  <= id_capacity;
            sector_4k <= id_sector_4k;
        end
    end

    assign m_busy     = busy_a[0];
    assign m_reject   = rej_a[0];
    assign m_be_start = start_a[0];
    assign m_be_cmd   = bcmd_a[0];
    assign m_be_addr  = baddr_a[0];
    assign m_be_len   = blen_a[0];
    assign s_busy     = busy_a[1];
    assign s_reject   = rej_a[1];
    assign s_be_start = start_a[1];
    assign s_be_cmd   = bcmd_a[1];
    assign s_be_addr  = baddr_a[1];
    assign s_be_len   = blen_a[1];
    assign locked     = (st_a[0] == PS_OFF) && (st_a[1] == PS_OFF);
endmodule

// File: rtl/cmdc_checker.sv
module cmdc_checker #(
    parameter int AW = 48,
    parameter int LW = 48
) (
    input logic          clk,
    input logic          rst_n,
    input logic          m_busy,
    input logic          m_reject,
    input logic          s_busy,
    input logic          s_reject,
    input logic          m_be_start,
    input logic [2:0]    m_be_cmd,
    input logic [AW-1:0] m_be_addr,
    input logic [LW-1:0] m_be_len,
    input logic          s_be_start,
    input logic [2:0]    s_be_cmd,
    input logic [AW-1:0] capacity,
    input logic          sector_4k,
    input logic          locked
);
    localparam int SW = ((AW > LW) ? AW : LW) + 1;

    // R3: a start is only issued from an idle port and leaves it busy
    a_r3_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        m_be_start |-> (m_busy && !$past(m_busy)));

    // R2: secondary back end only ever sees write or read
    a_r2_sec_codes: assert property (@(posedge clk) disable iff (!rst_n)
        s_be_start |-> (s_be_cmd == 3'b010 || s_be_cmd == 3'b011));

    // R10: refusal keeps the port idle and issues no start
    a_r10_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (m_reject || s_reject) |-> ((!m_reject || (!m_busy && !m_be_start)) &&
                                    (!s_reject || (!s_busy && !s_be_start))));

    // R7: accepted main transfer fits inside capacity known at decision time
    a_r7_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (m_be_start && (m_be_cmd == 3'b010 || m_be_cmd == 3'b011)) |->
            ((SW'(m_be_addr) + SW'(m_be_len)) <= SW'($past(capacity))));

    // R8: accepted main transfer is aligned in 4 KB mode
    a_r8_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (m_be_start && $past(sector_4k) && (m_be_cmd == 3'b010 || m_be_cmd == 3'b011)) |->
            (m_be_addr[2:0] == 3'b000 && m_be_len[2:0] == 3'b000));

    // R12: shutdown never starts beside a busy secondary port
    a_r12_shutdown_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (m_be_start && m_be_cmd == 3'b001) |-> !s_busy);

    // R13: inactive state persists with both ports busy
    a_r13_locked_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> (locked && m_busy && s_busy && !m_be_start && !s_be_start));
endmodule

bind dualport_cmd_ctrl cmdc_checker #(.AW(AW), .LW(LW)) u_cmdc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .m_busy     (m_busy),
    .m_reject   (m_reject),
    .s_busy     (s_busy),
    .s_reject   (s_reject),
    .m_be_start (m_be_start),
    .m_be_cmd   (m_be_cmd),
    .m_be_addr  (m_be_addr),
    .m_be_len   (m_be_len),
    .s_be_start (s_be_start),
    .s_be_cmd   (s_be_cmd),
    .capacity   (capacity),
    .sector_4k  (sector_4k),
    .locked     (locked)
);

// File: tb/dualport_cmd_ctrl_tb_top.sv
`timescale 1ns/100ps
module dualport_cmd_ctrl_tb_top;
    localparam int AW = 48;
    localparam int LW = 48;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          link_up = 1'b0;
    logic          m_req = 1'b0, s_req = 1'b0;
    logic [2:0]    m_cmd = '0, s_cmd = '0;
    logic [AW-1:0] m_addr = '0, s_addr = '0;
    logic [LW-1:0] m_len = '0, s_len = '0;
    logic          m_busy, s_busy, m_reject, s_reject;
    logic          m_be_start, s_be_start;
    logic [2:0]    m_be_cmd, s_be_cmd;
    logic [AW-1:0] m_be_addr, s_be_addr;
    logic [LW-1:0] m_be_len, s_be_len;
    logic          m_be_done = 1'b0, s_be_done = 1'b0;
    logic [AW-1:0] id_capacity = '0;
    logic          id_sector_4k = 1'b0;
    logic [AW-1:0] capacity;
    logic          sector_4k, locked;

    always #2.5 clk = ~clk;

    dualport_cmd_ctrl #(.AW(AW), .LW(LW), .INIT_CYCLES(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .link_up(link_up),
        .m_req(m_req), .m_cmd(m_cmd), .m_addr(m_addr), .m_len(m_len),
        .m_busy(m_busy), .m_reject(m_reject),
        .s_req(s_req), .s_cmd(s_cmd), .s_addr(s_addr), .s_len(s_len),
        .s_busy(s_busy), .s_reject(s_reject),
        .m_be_start(m_be_start), .m_be_cmd(m_be_cmd), .m_be_addr(m_be_addr),
        .m_be_len(m_be_len), .m_be_done(m_be_done),
        .s_be_start(s_be_start), .s_be_cmd(s_be_cmd), .s_be_addr(s_be_addr),
        .s_be_len(s_be_len), .s_be_done(s_be_done),
        .id_capacity(id_capacity), .id_sector_4k(id_sector_4k),
        .capacity(capacity), .sector_4k(sector_4k), .locked(locked)
    );

    typedef struct {
        int         port;
        bit         acc;
        logic [2:0] cmd;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   failures = 0;
    bit   finished = 0;

    task automatic check(input bit cond, input string tag, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!cond) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    task automatic note_event(input int p, input bit acc, input logic [2:0] c);
        exp_t e;
        if (exp_q.size() == 0) begin
            check(0, "R10", $sformatf("unexpected event port%0d", p), acc, 0);
        end else begin
            e = exp_q.pop_front();
            check(e.port == p, e.tag, "event port", p, e.port);
            check(e.acc == acc, e.tag, "accept/refuse", acc, e.acc);
            if (acc) check(c == e.cmd, e.tag, "started code", c, e.cmd);
        end
    endtask

    // Monitor: compares produced events with the scoreboard, main before secondary
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (m_be_start || m_reject) note_event(0, m_be_start, m_be_cmd);
            if (s_be_start || s_reject) note_event(1, s_be_start, s_be_cmd);
            if (m_be_start && m_reject) check(0, "R10", "main start and refuse together", 1, 0);
            if (s_be_start && s_reject) check(0, "R10", "sec start and refuse together", 1, 0);
        end
    end

    task automatic push(input int p, input bit acc, input logic [2:0] c, input string tag);
        exp_t e;
        e.port = p; e.acc = acc; e.cmd = c; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic set_req(input int p, input bit v, input logic [2:0] c,
                           input logic [AW-1:0] a, input logic [LW-1:0] l);
        if (p == 0) begin m_req = v; m_cmd = c; m_addr = a; m_len = l; end
        else        begin s_req = v; s_cmd = c; s_addr = a; s_len = l; end
    endtask

    task automatic issue(input int p, input logic [2:0] c, input logic [AW-1:0] a,
                         input logic [LW-1:0] l, input bit acc, input string tag);
        push(p, acc, c, tag);
        @(negedge clk);
        set_req(p, 1'b1, c, a, l);
        @(negedge clk);
        if (acc) check(((p == 0) ? m_busy : s_busy) == 1'b1, tag, "busy after accept", 0, 1);
        else     check(((p == 0) ? m_busy : s_busy) == 1'b0, tag, "busy after refuse", 1, 0);
        set_req(p, 1'b0, c, a, l);
    endtask

    task automatic finish_cmd(input int p, input logic [AW-1:0] cap, input bit k4,
                              input bit expect_busy, input string tag);
        @(negedge clk);
        id_capacity = cap; id_sector_4k = k4;
        if (p == 0) m_be_done = 1'b1; else s_be_done = 1'b1;
        @(negedge clk);
        m_be_done = 1'b0; s_be_done = 1'b0;
        check(((p == 0) ? m_busy : s_busy) == expect_busy, tag, "busy after done",
              (p == 0) ? m_busy : s_busy, expect_busy);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R5, R6: reset state
        check(m_busy && s_busy, "R5", "busy during init", m_busy & s_busy, 1);
        check(capacity == 0, "R6", "capacity reset", capacity, 0);
        check(sector_4k == 0, "R6", "sector mode reset", sector_4k, 0);
        // R5: requests before link-up are not accepted
        m_req = 1'b1; m_cmd = 3'b000;
        repeat (20) @(negedge clk);
        check(m_busy && s_busy, "R5", "busy held without link", m_busy, 1);
        m_req = 1'b0;
        link_up = 1'b1;
        @(negedge clk);
        check(m_busy, "R5", "busy right after link", m_busy, 1);
        for (int i = 0; i < 20 && m_busy; i++) @(negedge clk);
        check(!m_busy && !s_busy, "R5", "idle after init", m_busy | s_busy, 0);

        // R7: transfers refused while capacity is 0
        issue(0, 3'b010, 0, 1, 0, "R7");
        issue(1, 3'b011, 0, 1, 0, "R7");

        // R6: identify latches capacity
        issue(0, 3'b000, 0, 0, 1, "R1");
        finish_cmd(0, 48'd1000, 1'b0, 1'b0, "R3");
        check(capacity == 1000, "R6", "capacity after identify", capacity, 1000);
        check(sector_4k == 0, "R6", "sector mode after identify", sector_4k, 0);

        // R1, R2: code legality
        issue(0, 3'b101, 0, 1, 0, "R1");
        issue(0, 3'b111, 0, 1, 0, "R1");
        issue(1, 3'b000, 0, 1, 0, "R2");
        issue(1, 3'b100, 0, 1, 0, "R2");
        issue(0, 3'b110, 0, 0, 1, "R1");
        finish_cmd(0, 0, 0, 1'b0, "R1");
        issue(0, 3'b100, 0, 0, 1, "R1");
        finish_cmd(0, 0, 0, 1'b0, "R1");

        // R7, R9: range boundary and zero length
        issue(0, 3'b010, 990, 10, 1, "R7");
        // R3: a request while busy is ignored (monitor flags any event)
        @(negedge clk);
        m_req = 1'b1; m_cmd = 3'b110;
        repeat (4) @(negedge clk);
        check(!m_be_start && !m_reject && m_busy, "R3", "request while busy", m_be_start, 0);
        m_req = 1'b0;
        finish_cmd(0, 0, 0, 1'b0, "R3");
        issue(0, 3'b010, 991, 10, 0, "R7");
        issue(1, 3'b011, 0, 0, 0, "R9");

        // R10: a held refused request pulses once
        push(0, 0, 3'b111, "R10");
        @(negedge clk);
        m_req = 1'b1; m_cmd = 3'b111;
        repeat (5) @(negedge clk);
        check(!m_reject && !m_busy, "R10", "single refuse pulse", m_reject, 0);
        m_req = 1'b0;

        // R11, R4: same-cycle requests, main first, both run together
        push(0, 1, 3'b010, "R11");
        push(1, 1, 3'b011, "R11");
        @(negedge clk);
        m_req = 1'b1; m_cmd = 3'b010; m_addr = 0; m_len = 8;
        s_req = 1'b1; s_cmd = 3'b011; s_addr = 100; s_len = 8;
        @(negedge clk);
        check(m_be_start && !s_be_start, "R11", "main decided first", s_be_start, 0);
        @(negedge clk);
        check(m_busy && s_busy, "R4", "both ports busy", m_busy & s_busy, 1);
        m_req = 1'b0; s_req = 1'b0;
        finish_cmd(0, 0, 0, 1'b0, "R4");
        check(s_busy, "R4", "secondary still busy", s_busy, 1);
        finish_cmd(1, 0, 0, 1'b0, "R4");

        // R12: shutdown refused while secondary busy
        issue(1, 3'b010, 200, 4, 1, "R4");
        issue(0, 3'b001, 0, 0, 0, "R12");
        finish_cmd(1, 0, 0, 1'b0, "R4");

        // R6, R8: 4 KB mode alignment
        issue(0, 3'b000, 0, 0, 1, "R6");
        finish_cmd(0, 48'd4096, 1'b1, 1'b0, "R6");
        check(capacity == 4096 && sector_4k, "R6", "second identify", capacity, 4096);
        issue(0, 3'b010, 8, 8, 1, "R8");
        finish_cmd(0, 0, 0, 1'b0, "R8");
        issue(0, 3'b011, 9, 8, 0, "R8");
        issue(1, 3'b010, 8, 9, 0, "R8");
        issue(1, 3'b011, 4088, 8, 1, "R7");
        finish_cmd(1, 0, 0, 1'b0, "R7");

        // R12, R11: same-cycle shutdown and secondary write
        push(0, 1, 3'b001, "R12");
        push(1, 0, 3'b010, "R12");
        @(negedge clk);
        m_req = 1'b1; m_cmd = 3'b001;
        s_req = 1'b1; s_cmd = 3'b010; s_addr = 0; s_len = 8;
        @(negedge clk);
        @(negedge clk);
        check(!s_busy, "R12", "secondary refused during shutdown", s_busy, 0);
        m_req = 1'b0; s_req = 1'b0;

        // R13: shutdown completion locks both ports
        finish_cmd(0, 0, 0, 1'b1, "R13");
        check(locked, "R13", "locked after shutdown", locked, 1);
        @(negedge clk);
        m_req = 1'b1; m_cmd = 3'b000;
        s_req = 1'b1; s_cmd = 3'b011; s_len = 8;
        repeat (6) @(negedge clk);
        check(locked && m_busy && s_busy, "R13", "inactive ignores requests", locked, 1);
        m_req = 1'b0; s_req = 1'b0;
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R10", "scoreboard drained", exp_q.size(), 0);

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule